// File: doc/BRIEF.md
# Wake Interrupt Routing Register Block

This block collects pending flags from up to eight system-wake channels and passes up to eight peripheral interrupt lines through to the interrupt controller. Each system-wake channel has a pin sense unit outside the block. That unit reports a detected event as a one-cycle pulse. The pulse is held as a pending flag until software acknowledges it through a write-one-to-clear register. The pending flags that are also enabled combine into one shared system-wake interrupt. Each peripheral line is forwarded only while its routing enable bit is set.

A single routing register holds two kinds of bits. The forwarding enables pass each source on to the external interrupt path. The standby wake enables let a source raise a wake request while the system sleeps. Software reaches the four registers through a simple single-cycle read/write port. A read returns its data combinationally in the same cycle. A write takes effect at the next clock edge.

Top module: `wk_route_top`

## Requirements
- R1: After a synchronous reset, the pending, enable and routing registers read 0. `sys_irq`, `perip_irq` and `wake_req` are then all low while the peripheral inputs are low.
- R2: Register offsets are fixed: pending flags at 0x310, enable at 0x314, acknowledge at 0x318 and routing at 0x31C. A read of any other offset, or of the acknowledge register, returns 0. A write to any other offset changes nothing.
- R3: A detect pulse on system-wake channel n sets pending bit n, where bit 0 is channel 0. The pulse has this effect only while routing bit 8+n (forwarding of channel n) is 1. If that bit is 0, the pulse is dropped.
- R4: Writing 1 to bit n of the acknowledge register clears pending bit n at the next edge. Bits written as 0 leave their pending bits unchanged.
- R5: `sys_irq` is high exactly when some implemented channel has both its pending bit and its enable bit set.
- R6: `perip_irq[k]` equals `perip_in[k]` AND routing bit k. Peripheral k sits at bits 0..2 by default, for the real-time clock, infrared and watchdog lines.
- R7: `wake_req` is high exactly when at least one of two things holds. Either some peripheral k has `perip_in[k]` high together with routing bit 16+k, or some channel n has its pending bit set together with routing bit 24+n.
- R8: Bits above the implemented channel or peripheral count read as 0 and ignore writes. This applies to the enable and pending registers and to each of the four 8-bit groups of the routing register.
- R9: If a detect pulse and an acknowledge of the same channel fall in the same cycle, the pending bit ends up set.
- R10: A write to the pending register at 0x310 has no effect on its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| sys_detect | input | N_SYS | One-cycle event pulses from the pin sense units |
| perip_in | input | N_PERIP | Peripheral interrupt lines |
| sys_irq | output | 1 | Shared system-wake interrupt |
| perip_irq | output | N_PERIP | Gated peripheral interrupts |
| wake_req | output | 1 | Standby wake-up request |

## Verification
The acknowledge write and the event detect can land on the same pending bit in the same cycle, and the block must resolve that collision. The bench provokes this by driving a detect pulse on a channel in the same cycle as a write to 0x318 that names that channel. A reference model that lets the new event win decides the outcome. The bench compares the model with the pending readback, `sys_irq` and `wake_req` on every clock. A second overlap occurs when a routing write changes a forwarding bit in the same cycle as a detect pulse. Here the model applies the routing value that was in force before the write.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int MAX_LANES = 8;
    localparam int BUS_AW    = 12;
    localparam int BUS_DW    = 32;

    localparam logic [BUS_AW-1:0] OFS_PENDING = 12'h310;
    localparam logic [BUS_AW-1:0] OFS_ENABLE  = 12'h314;
    localparam logic [BUS_AW-1:0] OFS_ACK     = 12'h318;
    localparam logic [BUS_AW-1:0] OFS_ROUTE   = 12'h31C;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_PENDING,
        RSEL_ENABLE,
        RSEL_ACK,
        RSEL_ROUTE
    } reg_sel_e;

    // Bit groups of the routing register, most significant first.
    typedef struct packed {
        logic [MAX_LANES-1:0] wake_sys;
        logic [MAX_LANES-1:0] wake_per;
        logic [MAX_LANES-1:0] fwd_sys;
        logic [MAX_LANES-1:0] fwd_per;
    } route_t;

    typedef struct packed {
        logic enable_we;
        logic ack_we;
        logic route_we;
        logic rd;
    } bus_strobe_t;

    function automatic logic [MAX_LANES-1:0] lane_mask(input int count);
        logic [MAX_LANES-1:0] m;
        for (int i = 0; i < MAX_LANES; i++) begin
            m[i] = (i < count);
        end
        return m;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_PENDING: s = RSEL_PENDING;
            OFS_ENABLE:  s = RSEL_ENABLE;
            OFS_ACK:     s = RSEL_ACK;
            OFS_ROUTE:   s = RSEL_ROUTE;
            default:     s = RSEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wk_bus_decode.sv
module wk_bus_decode
    import wk_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    output reg_sel_e          rsel,
    output bus_strobe_t       strobe
);

    always_comb begin
        rsel             = decode_offset(bus_addr);
        strobe.enable_we = bus_sel && bus_wr && (rsel == RSEL_ENABLE);
        strobe.ack_we    = bus_sel && bus_wr && (rsel == RSEL_ACK);
        strobe.route_we  = bus_sel && bus_wr && (rsel == RSEL_ROUTE);
        strobe.rd        = bus_sel && !bus_wr;
    end

endmodule

// File: rtl/wk_pending.sv
module wk_pending
    import wk_pkg::*;
#(
    parameter int N_SYS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MAX_LANES-1:0] detect,
    input  logic [MAX_LANES-1:0] fwd,
    input  logic                 ack_we,
    input  logic [MAX_LANES-1:0] ack_bits,
    output logic [MAX_LANES-1:0] pending
);

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        if (i < N_SYS) begin : g_live
            logic hit;
            logic drop;
            assign hit  = detect[i] & fwd[i];
            assign drop = ack_we & ack_bits[i];
            always_ff @(posedge clk) begin
                if (rst) begin
                    pending[i] <= 1'b0;
                end else begin
                    // a fresh event outranks an acknowledge of the same lane
                    pending[i] <= hit | (pending[i] & ~drop);
                end
            end
        end else begin : g_tie
            assign pending[i] = 1'b0;
        end
    end

endmodule

// File: rtl/wk_cfg_regs.sv
module wk_cfg_regs
    import wk_pkg::*;
#(
    parameter int N_PERIP = 3,
    parameter int N_SYS   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_strobe_t          strobe,
    input  logic [BUS_DW-1:0]    wdata,
    output logic [MAX_LANES-1:0] enable_q,
    output route_t               route_q
);

    localparam logic [MAX_LANES-1:0] SYS_M = lane_mask(N_SYS);
    localparam logic [MAX_LANES-1:0] PER_M = lane_mask(N_PERIP);
    localparam logic [BUS_DW-1:0]    ROUTE_M = {SYS_M, PER_M, SYS_M, PER_M};

    route_t route_in;
    assign route_in = route_t'(wdata & ROUTE_M);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            route_q  <= '0;
        end else begin
            if (strobe.enable_we) begin
                enable_q <= wdata[MAX_LANES-1:0] & SYS_M;
            end
            if (strobe.route_we) begin
                route_q <= route_in;
            end
        end
    end

endmodule

// File: rtl/wk_fanout.sv
module wk_fanout
    import wk_pkg::*;
(
    input  logic [MAX_LANES-1:0] pending,
    input  logic [MAX_LANES-1:0] enable_q,
    input  route_t               route_q,
    input  logic [MAX_LANES-1:0] per_ext,
    output logic                 sys_irq,
    output logic [MAX_LANES-1:0] per_gated,
    output logic                 wake_req
);

    logic [MAX_LANES-1:0] live_sys;
    logic [MAX_LANES-1:0] wake_from_per;
    logic [MAX_LANES-1:0] wake_from_sys;

    always_comb begin
        live_sys      = pending & enable_q;
        per_gated     = per_ext & route_q.fwd_per;
        wake_from_per = per_ext & route_q.wake_per;
        wake_from_sys = pending & route_q.wake_sys;
        sys_irq       = |live_sys;
        wake_req      = (|wake_from_per) | (|wake_from_sys);
    end

endmodule

// File: rtl/wk_route_top.sv
module wk_route_top
    import wk_pkg::*;
#(
    parameter int N_PERIP = 3,
    parameter int N_SYS   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_SYS-1:0]   sys_detect,
    input  logic [N_PERIP-1:0] perip_in,
    output logic               sys_irq,
    output logic [N_PERIP-1:0] perip_irq,
    output logic               wake_req
);

    reg_sel_e             rsel;
    bus_strobe_t          strobe;
    logic [MAX_LANES-1:0] status_q;
    logic [MAX_LANES-1:0] enable_q;
    route_t               route_q;
    logic [MAX_LANES-1:0] det_ext;
    logic [MAX_LANES-1:0] per_ext;
    logic [MAX_LANES-1:0] per_gated;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_ext
        if (i < N_SYS) begin : g_det
            assign det_ext[i] = sys_detect[i];
        end else begin : g_det0
            assign det_ext[i] = 1'b0;
        end
        if (i < N_PERIP) begin : g_per
            assign per_ext[i] = perip_in[i];
        end else begin : g_per0
            assign per_ext[i] = 1'b0;
        end
    end

    wk_bus_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rsel     (rsel),
        .strobe   (strobe)
    );

    wk_pending #(.N_SYS(N_SYS)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .detect   (det_ext),
        .fwd      (route_q.fwd_sys),
        .ack_we   (strobe.ack_we),
        .ack_bits (bus_wdata[MAX_LANES-1:0]),
        .pending  (status_q)
    );

    wk_cfg_regs #(.N_PERIP(N_PERIP), .N_SYS(N_SYS)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .wdata    (bus_wdata),
        .enable_q (enable_q),
        .route_q  (route_q)
    );

    wk_fanout u_out (
        .pending   (status_q),
        .enable_q  (enable_q),
        .route_q   (route_q),
        .per_ext   (per_ext),
        .sys_irq   (sys_irq),
        .per_gated (per_gated),
        .wake_req  (wake_req)
    );

    assign perip_irq = per_gated[N_PERIP-1:0];

    always_comb begin
        bus_rdata = '0;
        if (strobe.rd) begin
            case (rsel)
                RSEL_PENDING: bus_rdata = {{(BUS_DW-MAX_LANES){1'b0}}, status_q};
                RSEL_ENABLE:  bus_rdata = {{(BUS_DW-MAX_LANES){1'b0}}, enable_q};
                RSEL_ROUTE:   bus_rdata = route_q;
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wk_route_chk.sv
module wk_route_chk #(
    parameter int N_PERIP = 3,
    parameter int N_SYS   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [7:0]         det_ext,
    input logic [7:0]         per_ext,
    input logic [7:0]         status_q,
    input logic [7:0]         enable_q,
    input logic [31:0]        route_q,
    input logic               sys_irq,
    input logic [N_PERIP-1:0] perip_irq,
    input logic               wake_req
);

    localparam logic [7:0]  SM = 8'((1 << N_SYS) - 1);
    localparam logic [7:0]  PM = 8'((1 << N_PERIP) - 1);
    localparam logic [31:0] RM = {SM, PM, SM, PM};

    logic ack_wr;
    assign ack_wr = bus_sel && bus_wr && (bus_addr == 12'h318);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (status_q == 8'h0 && enable_q == 8'h0 && route_q == 32'h0));

    // also covers the detect/acknowledge collision of R9
    p_detect_latches_r3: assert property (@(posedge clk) disable iff (rst)
        ((det_ext & route_q[15:8]) != 8'h0) |=>
        ((status_q & $past(det_ext & route_q[15:8])) == $past(det_ext & route_q[15:8])));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && det_ext == 8'h0) |=> ((status_q & $past(bus_wdata[7:0])) == 8'h0));

    p_pending_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (!ack_wr && det_ext == 8'h0) |=> $stable(status_q));

    p_shared_irq_r5: assert property (@(posedge clk) disable iff (rst)
        sys_irq == ((status_q & enable_q) != 8'h0));

    p_perip_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (perip_irq & ~route_q[N_PERIP-1:0]) == '0);

    p_wake_source_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (((per_ext & route_q[23:16]) != 8'h0) ||
                      ((status_q & route_q[31:24]) != 8'h0)));

    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ((route_q & ~RM) == 32'h0) && ((enable_q & ~SM) == 8'h0) &&
        ((status_q & ~SM) == 8'h0));

endmodule

bind wk_route_top wk_route_chk #(.N_PERIP(N_PERIP), .N_SYS(N_SYS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .det_ext   (det_ext),
    .per_ext   (per_ext),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .route_q   (route_q),
    .sys_irq   (sys_irq),
    .perip_irq (perip_irq),
    .wake_req  (wake_req)
);

// File: tb/wk_route_top_tb.sv
`timescale 1ns/1ps
module wk_route_top_tb_top;

    localparam int NP = 3;
    localparam int NS = 4;
    localparam logic [7:0]  SM = 8'((1 << NS) - 1);
    localparam logic [7:0]  PM = 8'((1 << NP) - 1);
    localparam logic [31:0] RM = {SM, PM, SM, PM};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] sys_detect = '0;
    logic [NP-1:0] perip_in = '0;
    logic          sys_irq;
    logic [NP-1:0] perip_irq;
    logic          wake_req;

    int errors = 0;
    int checks = 0;
    bit live = 1'b0;

    // reference state
    logic [7:0]  m_pend = '0;
    logic [7:0]  m_en = '0;
    logic [31:0] m_route = '0;

    always #10 clk = ~clk;

    wk_route_top #(.N_PERIP(NP), .N_SYS(NS)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_detect(sys_detect), .perip_in(perip_in), .sys_irq(sys_irq),
        .perip_irq(perip_irq), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [7:0] ack;
        logic [7:0] det;
        if (rst) begin
            m_pend  = '0;
            m_en    = '0;
            m_route = '0;
        end else begin
            ack = '0;
            det = 8'(sys_detect);
            if (bus_sel && bus_wr) begin
                if (bus_addr == 12'h318) ack = bus_wdata[7:0] & SM;
            end
            m_pend = (m_pend & ~ack) | (det & m_route[15:8]);
            if (bus_sel && bus_wr && bus_addr == 12'h314) m_en = bus_wdata[7:0] & SM;
            if (bus_sel && bus_wr && bus_addr == 12'h31C) m_route = bus_wdata & RM;
        end
    end

    function automatic logic [31:0] m_read();
        if (!bus_sel || bus_wr) return '0;
        case (bus_addr)
            12'h310: return {24'h0, m_pend};
            12'h314: return {24'h0, m_en};
            12'h31C: return m_route;
            default: return '0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (live) begin
            chk("R5 sys_irq", 32'(sys_irq), 32'((m_pend & m_en) != 0));
            chk("R6 perip_irq", 32'(perip_irq), 32'(perip_in & m_route[NP-1:0]));
            chk("R7 wake_req", 32'(wake_req),
                32'(((8'(perip_in) & m_route[23:16]) != 0) || ((m_pend & m_route[31:24]) != 0)));
            chk("R2 R8 rdata", bus_rdata, m_read());
        end
    end

    // tasks start at posedge+2 and end at the next posedge+2
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [NS-1:0] det);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sys_detect = det;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; sys_detect = '0;
    endtask

    task automatic pulse(input logic [NS-1:0] det);
        sys_detect = det;
        @(posedge clk); #2;
        sys_detect = '0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        @(posedge clk); #2;
        bus_sel = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #2;
        rd("R1 pending after reset", 12'h310, 32'h0);
        rd("R1 enable after reset", 12'h314, 32'h0);
        rd("R1 route after reset", 12'h31C, 32'h0);
        chk("R1 sys_irq after reset", 32'(sys_irq), 32'h0);
        chk("R1 wake_req after reset", 32'(wake_req), 32'h0);
        rst = 1'b0;
        live = 1'b1;

        // R3: forwarding still off, so the event is dropped
        pulse(4'b0100);
        rd("R3 dropped without forward", 12'h310, 32'h0);

        // R8: unimplemented bits are not stored
        wr(12'h31C, 32'hFFFF_FFFF, '0);
        rd("R8 route mask", 12'h31C, 32'h0F07_0F07);
        wr(12'h31C, 32'h0000_0F07, '0);
        wr(12'h314, 32'hFFFF_FFFF, '0);
        rd("R8 enable mask", 12'h314, 32'h0000_000F);

        // R3 / R5: latch and raise the shared irq
        pulse(4'b0100);
        rd("R3 channel 2 latched", 12'h310, 32'h4);
        chk("R5 shared irq set", 32'(sys_irq), 32'h1);

        // R4: zeros change nothing, ones clear
        wr(12'h318, 32'h0, '0);
        rd("R4 zero write keeps", 12'h310, 32'h4);
        wr(12'h318, 32'h4, '0);
        rd("R4 one write clears", 12'h310, 32'h0);
        chk("R5 shared irq clear", 32'(sys_irq), 32'h0);

        // R9: detect and acknowledge of channel 0 in one cycle
        pulse(4'b0011);
        wr(12'h318, 32'h3, 4'b0001);
        rd("R9 collision keeps bit", 12'h310, 32'h1);

        // R10: direct writes to the pending register are ignored
        wr(12'h310, 32'hFF, '0);
        rd("R10 pending not writable", 12'h310, 32'h1);
        wr(12'h310, 32'h0, '0);
        rd("R10 pending not clearable", 12'h310, 32'h1);

        // R2: unmapped offset is inert
        wr(12'h320, 32'hFFFF_FFFF, '0);
        rd("R2 unmapped reads zero", 12'h320, 32'h0);
        rd("R2 ack reads zero", 12'h318, 32'h0);
        rd("R2 route unchanged", 12'h31C, 32'h0000_0F07);

        // R5: masked pending does not raise the irq
        wr(12'h314, 32'h0, '0);
        chk("R5 masked pending", 32'(sys_irq), 32'h0);

        // R6: peripheral gating under several patterns
        perip_in = 3'b111; #1;
        chk("R6 all forwarded", 32'(perip_irq), 32'h7);
        wr(12'h31C, 32'h0000_0F05, '0);
        chk("R6 middle line blocked", 32'(perip_irq), 32'h5);
        perip_in = 3'b010; #1;
        chk("R6 blocked line only", 32'(perip_irq), 32'h0);

        // R7: wake from peripheral, then from pending channel
        chk("R7 no wake enables", 32'(wake_req), 32'h0);
        wr(12'h31C, 32'h0002_0F05, '0);
        chk("R7 wake from peripheral", 32'(wake_req), 32'h1);
        perip_in = '0; #1;
        chk("R7 peripheral idle", 32'(wake_req), 32'h0);
        wr(12'h31C, 32'h0100_0F05, '0);
        chk("R7 wake from channel 0", 32'(wake_req), 32'h1);
        wr(12'h318, 32'h1, '0);
        chk("R7 wake drops after ack", 32'(wake_req), 32'h0);

        // R3: a forward enable written together with a pulse uses the old value
        wr(12'h31C, 32'h0000_0000, '0);
        wr(12'h31C, 32'h0000_0800, 4'b1000);
        rd("R3 old forward applies", 12'h310, 32'h0);
        pulse(4'b1000);
        rd("R3 channel 3 latched", 12'h310, 32'h8);

        repeat (3) @(posedge clk);
        summary();
        $finish;
    end

endmodule